// File: doc/BRIEF.md
# Injection-Biased Significand Rounder

This block finishes the rounding of a non-negative significand product that arrives in carry-save form. The product has already been biased upstream by a constant chosen from the rounding mode. That bias turns round-to-nearest and round-up into plain truncation whenever the product lies in [1,2). The block adds the upper 54 carry-save bits with a three-way compound adder. It picks one of the candidates using the carry arriving from the lower part and a small correction that applies when the product lies in [2,4). It then normalizes the result and repairs the LSB and the leading bit. The output is a normalized rounded significand.

Both precisions run through one datapath. A single-precision product sits right-aligned, so that its LSB lands on the same weight as the double-precision LSB. The precision select changes only which sum bit acts as the range indicator and how the result is aligned at the output. Operands enter and results leave through valid/ready streams with one register stage. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while a result is held and `out_ready` is low. A held result stays unchanged until the edge where `out_ready` is high.

Top module: `rir_round_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The 2-bit mode is encoded as 0 for nearest-even, 1 for toward zero, 2 for toward +infinity and 3 for toward -infinity. Modes 2 and 3 act as magnitude ceiling when the sign points the same way (mode 2 with sign 0, mode 3 with sign 1). They act as truncation otherwise.
- R3: For toward-zero, and for the directed modes that reduce to truncation, the output is the exact product truncated at the result LSB.
- R4: When a directed mode reduces to ceiling, any nonzero discarded part raises the result by one LSB.
- R5: Nearest-even rounds to the nearer value. An exact midpoint goes to the value with LSB 0, both for products in [1,2) and for products in [2,4).
- R6: Input bit i of `in_sum` and `in_carry` weighs 2^(i-52). `in_cin` adds at bit 0. `in_rnd` is the bit of weight 2^-53 of the biased lower part, and `in_stk` is the OR of all lower bits. The result is correct even when the range indicator (sum bit 53 in double, 24 in single, computed without `in_cin`) disagrees with the true range, as for products just below 2.
- R7: Products in [2,4) are shifted right by one. Every output has its leading bit at bit 52, which weighs 2^0.
- R8: A result that rounds up to exactly 2 is delivered as bit 52 set and all other bits clear.
- R9: With `in_single` = 1, the 24-bit result occupies bits 52..29 and bits 28..0 are 0.
- R10: An input accepted on a clock edge gives `out_valid` = 1 with its result after that edge. While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and no new input is taken.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_sig` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operand valid |
| in_ready | output | 1 | Block can take an input |
| in_sum | input | 54 | Sum vector of upper product bits |
| in_carry | input | 54 | Carry vector of upper product bits |
| in_cin | input | 1 | Carry from the lower part into bit 0 |
| in_rnd | input | 1 | Round bit (weight 2^-53) |
| in_stk | input | 1 | Sticky bit below the round bit |
| in_mode | input | 2 | IEEE rounding mode |
| in_sign | input | 1 | Sign of the product |
| in_single | input | 1 | 1 selects single precision |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_sig | output | 53 | Normalized rounded significand |

## Verification
The bench uses the default widths: a 53-bit double significand and a 24-bit single significand, which gives an alignment shift of 29. This reaches both precisions and all four modes, using real products of random significands and directly built values. The directly built values include exact midpoints in both ranges, values just below 2 with a forced carry-in that misleads the range bit, and rounding up to exactly 2. It also covers back-pressure, with a second operand waiting while the output is held.

// File: rtl/rir_pkg.sv
package rir_pkg;
  // Rounding mode encoding at the block input
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_TO_POS    = 2'd2,
    RM_TO_NEG    = 2'd3
  } rmode_e;

  // Reduced rounding class of a magnitude: nearest (as nearest-up) or ceiling;
  // neither bit set means truncation
  typedef struct packed {
    logic near;
    logic ceil;
  } rclass_t;
endpackage

// File: rtl/rir_mode_map.sv
module rir_mode_map
  import rir_pkg::*;
(
  input  rmode_e  mode,
  input  logic    sign,
  output rclass_t cls
);
  always_comb begin
    cls.near = (mode == RM_NEAR_EVEN);
    cls.ceil = ((mode == RM_TO_POS) && !sign) || ((mode == RM_TO_NEG) && sign);
  end
endmodule

// File: rtl/rir_compound_add.sv
module rir_compound_add #(
  parameter int W     = 54,
  parameter int TAP_S = 24
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         single,
  output logic         msb,
  output logic [W-1:0] x,
  output logic [W-1:0] x1
);
  logic [W-1:0] s0, s1, s2;

  // three candidate sums of the upper carry-save part
  always_comb begin
    s0 = a + b;
    s1 = a + b + W'(1);
    s2 = a + b + W'(2);
    // carry from the lower part picks the candidate pair
    x   = cin ? s1 : s0;
    x1  = cin ? s2 : s1;
    // range indicator taken from the plain sum, carry-in deliberately left out
    msb = single ? s0[TAP_S] : s0[W-1];
  end
endmodule

// File: rtl/rir_normalize.sv
module rir_normalize
  import rir_pkg::*;
#(
  parameter int UP_W  = 54,
  parameter int ALIGN = 29
) (
  input  logic [UP_W-1:0] x,
  input  logic [UP_W-1:0] x1,
  input  logic            msb,
  input  rclass_t         cls,
  input  logic            rnd,
  input  logic            stk,
  input  logic            single,
  output logic [UP_W-2:0] sig
);
  localparam int SIG_W = UP_W - 1;
  localparam int TAP_S = UP_W - 1 - ALIGN;

  logic            cor, tie;
  logic [UP_W-1:0] y, t, tf;
  logic [SIG_W-1:0] sig_d, sig_s;

  always_comb begin
    // late part of the bias for the upper range
    cor = msb & (cls.ceil | (cls.near & rnd));
    y   = cor ? x1 : x;
    // one shared right shifter for both precisions
    t   = msb ? (y >> 1) : y;
    // exact midpoint under nearest-even: lower range leaves R=0,S=0;
    // upper range leaves bit 0 of x, R set and S clear
    tie = cls.near & ~stk & (msb ? (rnd & x[0]) : ~rnd);
    tf  = {t[UP_W-1:1], t[0] & ~tie};
    // leading bit absorbs a carry into the position above
    sig_d = {tf[UP_W-1] | tf[UP_W-2], tf[UP_W-3:0]};
    sig_s = {tf[TAP_S] | tf[TAP_S-1], tf[TAP_S-2:0], {ALIGN{1'b0}}};
    sig   = single ? sig_s : sig_d;
  end
endmodule

// File: rtl/rir_round_top.sv
module rir_round_top
  import rir_pkg::*;
#(
  parameter int SIG_W = 53,
  parameter int SGL_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SIG_W:0]   in_sum,
  input  logic [SIG_W:0]   in_carry,
  input  logic             in_cin,
  input  logic             in_rnd,
  input  logic             in_stk,
  input  logic [1:0]       in_mode,
  input  logic             in_sign,
  input  logic             in_single,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SIG_W-1:0] out_sig
);
  localparam int UP_W  = SIG_W + 1;
  localparam int ALIGN = SIG_W - SGL_W;
  localparam int TAP_S = UP_W - 1 - ALIGN;

  rclass_t          cls;
  logic             msb;
  logic [UP_W-1:0]  x, x1;
  logic [SIG_W-1:0] sig_c;

  rir_mode_map u_map (
    .mode (rmode_e'(in_mode)),
    .sign (in_sign),
    .cls  (cls)
  );

  rir_compound_add #(.W(UP_W), .TAP_S(TAP_S)) u_add (
    .a      (in_sum),
    .b      (in_carry),
    .cin    (in_cin),
    .single (in_single),
    .msb    (msb),
    .x      (x),
    .x1     (x1)
  );

  rir_normalize #(.UP_W(UP_W), .ALIGN(ALIGN)) u_norm (
    .x      (x),
    .x1     (x1),
    .msb    (msb),
    .cls    (cls),
    .rnd    (in_rnd),
    .stk    (in_stk),
    .single (in_single),
    .sig    (sig_c)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_sig <= sig_c;
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_sig));

  // R10
  accept_out_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R7
  lead_one_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_sig[SIG_W-1]);

  // R9
  single_pad_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(in_valid && in_ready && in_single) |-> out_sig[ALIGN-1:0] == '0);
endmodule

// File: tb/test_rir_round_top.sv
module test_rir_round_top;
  localparam logic [107:0] ONE = 108'd1;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [53:0] in_sum, in_carry;
  logic        in_cin, in_rnd, in_stk;
  logic [1:0]  in_mode;
  logic        in_sign, in_single;
  logic        out_valid, out_ready;
  logic [52:0] out_sig;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  rir_round_top i_rir_round_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sum(in_sum), .in_carry(in_carry), .in_cin(in_cin), .in_rnd(in_rnd),
    .in_stk(in_stk), .in_mode(in_mode), .in_sign(in_sign), .in_single(in_single),
    .out_valid(out_valid), .out_ready(out_ready), .out_sig(out_sig)
  );

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // exact rounding of e (units of 2^-104) to a normalized significand
  function automatic logic [52:0] ref_round(input logic [107:0] e, input logic [1:0] m,
                                            input logic sg, input logic sp);
    logic [107:0] thr, q, rem, half, r;
    logic up, ceilm;
    int sh;
    thr   = sp ? (ONE << 76) : (ONE << 105);
    ceilm = (m == 2'd2 && !sg) || (m == 2'd3 && sg);
    sh    = (e >= thr) ? 53 : 52;
    q     = e >> sh;
    rem   = e & ((ONE << sh) - ONE);
    half  = ONE << (sh - 1);
    if (m == 2'd0)  up = (rem > half) || (rem == half && q[0]);
    else if (ceilm) up = (rem != 0);
    else            up = 1'b0;
    r = (q + 108'(up)) << sh;
    q = r >> ((r >= thr) ? 53 : 52);
    if (sp) q = q << 29;
    return q[52:0];
  endfunction

  // cmode: 0 or 1 forces the carry-in, 2 picks it at random
  task automatic set_inputs(input logic [107:0] e, input logic [1:0] m, input logic sg,
                            input logic sp, input int cmode);
    logic [107:0] inj, t;
    logic [53:0]  ucs, sr;
    logic         c, ceilm;
    ceilm = (m == 2'd2 && !sg) || (m == 2'd3 && sg);
    if (m == 2'd0)  inj = ONE << 51;
    else if (ceilm) inj = (ONE << 52) - ONE;
    else            inj = '0;
    t   = e + inj;
    c   = (cmode == 2) ? 1'($urandom % 2) : 1'(cmode);
    ucs = t[105:52] - 54'(c);
    sr  = {22'($urandom), 32'($urandom)};
    in_sum    = sr;
    in_carry  = ucs - sr;
    in_cin    = c;
    in_rnd    = t[51];
    in_stk    = |t[50:0];
    in_mode   = m;
    in_sign   = sg;
    in_single = sp;
  endtask

  task automatic send(input logic [107:0] e, input logic [1:0] m, input logic sg,
                      input logic sp, input int cmode, input string tag);
    logic [52:0] exp;
    exp = ref_round(e, m, sg, sp);
    @(negedge clk);
    set_inputs(e, m, sg, sp, cmode);
    in_valid  = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {tag, " R10 valid"}, 64'(out_valid), 64'd1);
    check(out_sig == exp, tag, 64'(out_sig), 64'(exp));
  endtask

  function automatic logic [107:0] rnd_dbl_prod();
    logic [52:0] a, b;
    a = {1'b1, 20'($urandom), 32'($urandom)};
    b = {1'b1, 20'($urandom), 32'($urandom)};
    return 108'(a) * 108'(b);
  endfunction

  function automatic logic [107:0] rnd_sgl_prod();
    logic [23:0] a, b;
    a = {1'b1, 23'($urandom)};
    b = {1'b1, 23'($urandom)};
    return (108'(a) * 108'(b)) << 29;
  endfunction

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    in_sum = '0; in_carry = '0; in_cin = 1'b0; in_rnd = 1'b0; in_stk = 1'b0;
    in_mode = '0; in_sign = 1'b0; in_single = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_truncate();
    logic [107:0] e;
    e = (ONE << 104) | (ONE << 60) | (ONE << 51) | 108'd5;
    send(e, 2'd1, 1'b0, 1'b0, 2, "R3 toward zero lower range");
    check(out_sig == 53'(e >> 52), "R3 truncation literal", 64'(out_sig), 64'(e >> 52));
    send(e, 2'd3, 1'b0, 1'b0, 2, "R2 R3 -inf on positive truncates");
    send(e, 2'd2, 1'b1, 1'b0, 2, "R2 R3 +inf on negative truncates");
    for (int i = 0; i < 20; i++) send(rnd_dbl_prod(), 2'd1, 1'($urandom % 2), 1'b0, 2, "R3 random truncate");
  endtask

  task automatic t_ceiling();
    logic [107:0] e;
    e = (ONE << 104) | 108'd1;
    send(e, 2'd2, 1'b0, 1'b0, 2, "R2 R4 +inf positive tiny tail");
    check(out_sig == 53'((ONE << 52) + ONE), "R4 ceiling literal", 64'(out_sig), 64'((ONE << 52) + ONE));
    send(e, 2'd3, 1'b1, 1'b0, 2, "R2 R4 -inf negative tiny tail");
    send(ONE << 104, 2'd2, 1'b0, 1'b0, 2, "R4 exact value not raised");
    send((ONE << 105) | (ONE << 52), 2'd2, 1'b0, 1'b0, 2, "R4 upper range tail at bit -52");
    for (int i = 0; i < 20; i++) send(rnd_dbl_prod(), 2'd2, 1'b0, 1'b0, 2, "R4 random ceiling");
  endtask

  task automatic t_ties();
    logic [107:0] k;
    k = (ONE << 52);
    send((k << 52) | (ONE << 51), 2'd0, 1'b0, 1'b0, 2, "R5 lower tie even stays");
    check(out_sig == 53'(ONE << 52), "R5 lower tie literal", 64'(out_sig), 64'(ONE << 52));
    send(((k + 1) << 52) | (ONE << 51), 2'd0, 1'b0, 1'b0, 2, "R5 lower tie odd up");
    send(((k + 6) << 53) | (ONE << 52), 2'd0, 1'b1, 1'b0, 2, "R5 upper tie even stays");
    send(((k + 7) << 53) | (ONE << 52), 2'd0, 1'b0, 1'b0, 2, "R5 upper tie odd up");
    send(((k + 7) << 53) | (ONE << 52) | ONE, 2'd0, 1'b0, 1'b0, 2, "R5 upper just above tie");
    send(((k + 8) << 52) | (ONE << 51) - ONE, 2'd0, 1'b0, 1'b0, 2, "R5 lower just below tie");
    for (int i = 0; i < 20; i++) send(rnd_dbl_prod(), 2'd0, 1'b0, 1'b0, 2, "R5 random nearest");
  endtask

  task automatic t_near_two();
    logic [107:0] e;
    e = (ONE << 105) - ONE;
    for (int m = 0; m < 4; m++) begin
      send(e, 2'(m), 1'b0, 1'b0, 1, "R6 just below two forced carry");
      send(e, 2'(m), 1'b0, 1'b0, 0, "R6 just below two no carry");
    end
    send(ONE << 105, 2'd1, 1'b0, 1'b0, 1, "R6 exactly two with carry-in");
    send((((ONE << 53) - ONE) << 52) | (ONE << 51), 2'd0, 1'b0, 1'b0, 1, "R8 tie rounds to two");
    check(out_sig == 53'(ONE << 52), "R8 two as one point zero", 64'(out_sig), 64'(ONE << 52));
    send(e, 2'd2, 1'b0, 1'b0, 2, "R8 ceiling to two");
    check(out_sig == 53'(ONE << 52), "R8 ceiling literal", 64'(out_sig), 64'(ONE << 52));
  endtask

  task automatic t_upper_range();
    for (int i = 0; i < 30; i++) begin
      logic [107:0] e;
      e = rnd_dbl_prod();
      if (e < (ONE << 105)) e = e << 1;
      send(e, 2'($urandom % 4), 1'($urandom % 2), 1'b0, 2, "R7 upper range");
    end
    send(ONE << 105, 2'd0, 1'b0, 1'b0, 0, "R7 exactly two");
    check(out_sig == 53'(ONE << 52), "R7 two literal", 64'(out_sig), 64'(ONE << 52));
  endtask

  task automatic t_single();
    logic [107:0] k;
    k = ONE << 23;
    send((k << 52) | (ONE << 51), 2'd0, 1'b0, 1'b1, 2, "R9 single lower tie");
    check(out_sig == 53'(ONE << 52), "R9 single literal", 64'(out_sig), 64'(ONE << 52));
    send(((k + 3) << 53) | (ONE << 52), 2'd0, 1'b0, 1'b1, 2, "R9 single upper tie odd");
    send(((k + 5) << 52) | ONE, 2'd2, 1'b0, 1'b1, 2, "R9 single ceiling tail");
    send((ONE << 76) - ONE, 2'd2, 1'b0, 1'b1, 1, "R9 single just below two");
    for (int i = 0; i < 60; i++)
      send(rnd_sgl_prod(), 2'($urandom % 4), 1'($urandom % 2), 1'b1, 2, "R9 single random");
  endtask

  task automatic t_stall();
    logic [107:0] ea, eb;
    logic [52:0]  xa, xb;
    ea = rnd_dbl_prod();
    eb = rnd_sgl_prod();
    xa = ref_round(ea, 2'd0, 1'b0, 1'b0);
    xb = ref_round(eb, 2'd1, 1'b0, 1'b1);
    @(negedge clk);
    set_inputs(ea, 2'd0, 1'b0, 1'b0, 2);
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check(out_valid && out_sig == xa, "R10 first result held", 64'(out_sig), 64'(xa));
    set_inputs(eb, 2'd1, 1'b0, 1'b1, 2);
    check(in_ready == 1'b0, "R10 in_ready low during stall", 64'(in_ready), 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R11 valid held", 64'(out_valid), 64'd1);
      check(out_sig == xa, "R11 data held", 64'(out_sig), 64'(xa));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_sig == xb, "R10 waiting input taken after release", 64'(out_sig), 64'(xb));
    @(negedge clk);
    check(out_valid == 1'b0, "R10 drained", 64'(out_valid), 64'd0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 150; i++)
      send(rnd_dbl_prod(), 2'($urandom % 4), 1'($urandom % 2), 1'b0, 2, "R2 random double all modes");
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_truncate();
    t_ceiling();
    t_ties();
    t_near_two();
    t_upper_range();
    t_single();
    t_stall();
    t_random();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule